// File: doc/BRIEF.md
# Multi-Output Bridge PWM Generator

This block produces a pulse-width-modulated waveform with 10-bit duty resolution. It steers the waveform onto four output lines (A, B, C, D) in one of four patterns: a single line, a complementary half-bridge pair, or a full bridge driven in either direction. The time base is built inside the block. An 8-bit period timer forms the upper bits and a free-running 2-bit sub-counter forms the lower bits, so one period lasts `(period + 1) * 4` clock cycles.

Software programs the block through a simple write port with three registers: control, period and the upper duty bits. Each duty write goes to a buffer. The working duty value is reloaded from that buffer only at a period boundary, so a period that has already started always completes with the duty it began with. A one-cycle tick marks the start of every period.

Top module: `bridge_pwm`

## Requirements
- R1: After reset all four lines and `period_tick` are low and the block is disabled.
- R2: When enabled, `period_tick` is a single-cycle pulse that repeats every `(P + 1) * 4` cycles, where P is the period register (write address 1).
- R3: At each period start the time base restarts at zero and the modulated signal turns active. The signal returns inactive once the 10-bit time base reaches the latched duty value, so it stays active for `min(duty, (P + 1) * 4)` cycles of each period.
- R4: The 10-bit duty value is formed from two fields. Its upper 8 bits come from write address 2. Its lower 2 bits come from control bits [4:3].
- R5: A duty of zero keeps the modulated signal inactive for the whole period. A duty of at least `(P + 1) * 4` keeps it active for the whole period.
- R6: Writes to either duty field reach only a buffer. The period already running keeps its old duty, and the new value applies from the next period.
- R7: The control register is at write address 0, with enable at bit 0. While enable is 0, every line is low, no tick is produced and the time base is held at zero. Writing 0 to the control register forces all lines low from the next cycle.
- R8: Mode code 00 is single output. The line bus is `pwm_lines`, with bit 0 = A, bit 1 = B, bit 2 = C and bit 3 = D. Control bits [2:1] hold the mode. In this mode line A carries the modulated signal and lines B, C and D are low.
- R9: Mode code 01 is half-bridge. Line A carries the modulated signal, line B carries its complement, and lines C and D are low.
- R10: Mode code 10 is full-bridge forward. Line A is held high, line D carries the modulated signal, and lines B and C are low.
- R11: Mode code 11 is full-bridge reverse. Line C is held high, line B carries the modulated signal, and lines A and D are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty upper bits, 3 unused |
| wr_data | input | 8 | Write data |
| pwm_lines | output | 4 | Output lines, bit 0 = A through bit 3 = D |
| period_tick | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench measures whole periods, starting at the tick, and counts the active cycles on every line. A duty wrongly compared on the upper bits alone, or a lost lower field, shows up as a count that is off by the fractional part. The two duty extremes are tested separately. A value of zero must give no pulse at all, and a duty of at least the period length must hold the line high for the full period; an off-by-one set/reset order gives a single-cycle glitch or a gap in those cases. A duty write made a few cycles into a period must leave that period's count unchanged, which exposes an unbuffered latch. Clearing the control register must silence every line at once, including the line that is held high in bridge modes.

// File: rtl/bpwm_pkg.sv
// Package: shared types, register addresses and the line steering table
// for the bridge PWM generator. Assumes a 2-bit mode code and four lines.
package bpwm_pkg;

    localparam int LINE_CNT = 4;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_DUTY   = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_LSB = 1;
    localparam int CTRL_FRAC_LSB = 3;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_HALF   = 2'b01,
        MODE_FWD    = 2'b10,
        MODE_REV    = 2'b11
    } bridge_mode_e;

    typedef enum logic [1:0] {
        DRV_OFF = 2'b00,
        DRV_MOD = 2'b01,
        DRV_INV = 2'b10,
        DRV_ON  = 2'b11
    } line_drv_e;

    // How a given line (0 = A .. 3 = D) is driven in a given mode.
    function automatic line_drv_e drive_for(bridge_mode_e m, int line);
        line_drv_e d;
        d = DRV_OFF;
        case (m)
            MODE_SINGLE: if (line == 0) d = DRV_MOD;
            MODE_HALF: begin
                if (line == 0) d = DRV_MOD;
                if (line == 1) d = DRV_INV;
            end
            MODE_FWD: begin
                if (line == 0) d = DRV_ON;
                if (line == 3) d = DRV_MOD;
            end
            MODE_REV: begin
                if (line == 2) d = DRV_ON;
                if (line == 1) d = DRV_MOD;
            end
            default: d = DRV_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bpwm_regs.sv
// Register file: decodes the write port into enable, mode, period and the
// buffered 10-bit duty value. Assumes DATA_W >= CTRL_FRAC_LSB + SUB_W.
module bpwm_regs
    import bpwm_pkg::*;
#(
    parameter int TIMER_W = 8,
    parameter int SUB_W   = 2,
    localparam int DUTY_W = TIMER_W + SUB_W,
    localparam int DATA_W = TIMER_W,
    localparam int CTRL_USED = CTRL_FRAC_LSB + SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               en_o,
    output bridge_mode_e       mode_o,
    output logic [TIMER_W-1:0] period_o,
    output logic [DUTY_W-1:0]  duty_buf_o
);

    logic [TIMER_W-1:0] duty_hi_q;
    logic [SUB_W-1:0]   duty_lo_q;

    // Register update from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            mode_o    <= MODE_SINGLE;
            period_o  <= '0;
            duty_hi_q <= '0;
            duty_lo_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    en_o      <= wr_data[CTRL_EN_BIT];
                    mode_o    <= bridge_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
                    duty_lo_q <= wr_data[CTRL_FRAC_LSB +: SUB_W];
                end
                ADDR_PERIOD: period_o  <= wr_data;
                ADDR_DUTY:   duty_hi_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Buffered duty: upper bits from the duty register, lower from control.
    assign duty_buf_o = {duty_hi_q, duty_lo_q};

    // Reserved control bits carry no function.
    generate
        if (DATA_W > CTRL_USED) begin : g_rsvd
            logic rsvd_bits_unused;
            assign rsvd_bits_unused = ^wr_data[DATA_W-1:CTRL_USED];
        end
    endgenerate

endmodule

// File: rtl/bpwm_timebase.sv
// Time base: a SUB_W-bit sub-counter below a TIMER_W-bit period timer.
// The timer restarts on the sub-counter wrap that finds it equal to the
// period. Assumes the period input may change at any time; a timer already
// above a lowered period runs on to its natural wrap.
module bpwm_timebase #(
    parameter int TIMER_W = 8,
    parameter int SUB_W   = 2,
    localparam int TB_W   = TIMER_W + SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [TIMER_W-1:0] period_i,
    output logic [TB_W-1:0]    tb_o,
    output logic [TB_W-1:0]    tb_next_o,
    output logic               match_evt_o,
    output logic               match_o
);

    localparam logic [SUB_W-1:0] SUB_LAST = '1;

    logic [SUB_W-1:0]   sub_q, sub_d;
    logic [TIMER_W-1:0] timer_q, timer_d;
    logic               sub_wrap;

    assign sub_wrap    = (sub_q == SUB_LAST);
    assign match_evt_o = en_i && sub_wrap && (timer_q == period_i);

    // Next-state of sub-counter and timer, held at zero while disabled.
    always_comb begin
        sub_d   = sub_q;
        timer_d = timer_q;
        if (!en_i) begin
            sub_d   = '0;
            timer_d = '0;
        end else if (sub_wrap) begin
            sub_d   = '0;
            timer_d = match_evt_o ? '0 : timer_q + 1'b1;
        end else begin
            sub_d = sub_q + 1'b1;
        end
    end

    // Counter and tick registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= '0;
            timer_q <= '0;
            match_o <= 1'b0;
        end else begin
            sub_q   <= sub_d;
            timer_q <= timer_d;
            match_o <= match_evt_o;
        end
    end

    assign tb_o      = {timer_q, sub_q};
    assign tb_next_o = {timer_d, sub_d};

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (tb_o == '0)); // R3
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o); // R2
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tb_o == '0)); // R7

endmodule

// File: rtl/bpwm_modulator.sv
// Modulator: keeps the working duty latch and the set/reset PWM flop.
// At a period match the buffered duty is loaded and the signal is set
// (unless the new duty is zero); it resets when the next time base value
// equals the working duty. Assumes the time base visits every value.
module bpwm_modulator #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              match_evt_i,
    input  logic [DUTY_W-1:0] tb_next_i,
    input  logic [DUTY_W-1:0] duty_buf_i,
    output logic              pwm_o
);

    logic [DUTY_W-1:0] duty_q;

    // Working duty latch: loaded only on a period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (match_evt_i) begin
            duty_q <= duty_buf_i;
        end
    end

    // Set/reset PWM flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_o <= 1'b0;
        end else if (!en_i) begin
            pwm_o <= 1'b0;
        end else if (match_evt_i) begin
            pwm_o <= (duty_buf_i != '0);
        end else if (tb_next_i == duty_q) begin
            pwm_o <= 1'b0;
        end
    end

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_evt_i |=> $stable(duty_q)); // R6
    AST_ZERO_DUTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o |-> (duty_q != '0)); // R5

endmodule

// File: rtl/bpwm_steer.sv
// Steering: maps the modulated signal onto the four lines according to
// the mode code; every line is low while disabled. Purely combinational.
module bpwm_steer
    import bpwm_pkg::*;
(
    input  logic                en_i,
    input  bridge_mode_e        mode_i,
    input  logic                pwm_i,
    output logic [LINE_CNT-1:0] lines_o
);

    for (genvar gi = 0; gi < LINE_CNT; gi++) begin : g_line
        line_drv_e drv;
        assign drv = drive_for(mode_i, gi);

        // Drive one line from its table entry.
        always_comb begin
            case (drv)
                DRV_MOD: lines_o[gi] = en_i & pwm_i;
                DRV_INV: lines_o[gi] = en_i & ~pwm_i;
                DRV_ON:  lines_o[gi] = en_i;
                default: lines_o[gi] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/bridge_pwm.sv
// Top: bridge PWM generator. Joins the register file, time base,
// modulator and line steering. Period length is (P + 1) << SUB_W cycles.
module bridge_pwm
    import bpwm_pkg::*;
#(
    parameter int TIMER_W = 8,
    parameter int SUB_W   = 2,
    localparam int DUTY_W = TIMER_W + SUB_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [TIMER_W-1:0]  wr_data,
    output logic [LINE_CNT-1:0] pwm_lines,
    output logic                period_tick
);

    logic               en;
    bridge_mode_e       mode;
    logic [TIMER_W-1:0] period;
    logic [DUTY_W-1:0]  duty_buf;
    logic [DUTY_W-1:0]  tb, tb_next;
    logic               match_evt;
    logic               pwm_mod;

    bpwm_regs #(.TIMER_W(TIMER_W), .SUB_W(SUB_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .en_o       (en),
        .mode_o     (mode),
        .period_o   (period),
        .duty_buf_o (duty_buf)
    );

    bpwm_timebase #(.TIMER_W(TIMER_W), .SUB_W(SUB_W)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .period_i    (period),
        .tb_o        (tb),
        .tb_next_o   (tb_next),
        .match_evt_o (match_evt),
        .match_o     (period_tick)
    );

    bpwm_modulator #(.DUTY_W(DUTY_W)) u_mod (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .match_evt_i (match_evt),
        .tb_next_i   (tb_next),
        .duty_buf_i  (duty_buf),
        .pwm_o       (pwm_mod)
    );

    bpwm_steer u_steer (
        .en_i    (en),
        .mode_i  (mode),
        .pwm_i   (pwm_mod),
        .lines_o (pwm_lines)
    );

    logic tb_view_unused;
    assign tb_view_unused = ^tb;

    AST_HALF_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_HALF) |-> (pwm_lines[1] == !pwm_mod)); // R9
    AST_OFF_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_lines == '0)); // R7

endmodule

// File: tb/bridge_pwm_test.sv
module bridge_pwm_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] period;
        logic [9:0] duty;
        logic [9:0] active;
    } vec_t;

    // Stimulus and expected active cycles per period, min(duty, (P+1)*4).
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'd3, 10'd5,   10'd5},
        '{2'b01, 8'd3, 10'd10,  10'd10},
        '{2'b10, 8'd7, 10'd20,  10'd20},
        '{2'b11, 8'd7, 10'd1,   10'd1},
        '{2'b00, 8'd2, 10'd0,   10'd0},
        '{2'b01, 8'd2, 10'd200, 10'd12},
        '{2'b10, 8'd0, 10'd3,   10'd3},
        '{2'b11, 8'd5, 10'd24,  10'd24}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_lines;
    logic       period_tick;

    int checks = 0;
    int errors = 0;

    int cnt [4];
    int tick_cnt;
    int compl_bad;
    bit next_tick;

    bridge_pwm uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_lines   (pwm_lines),
        .period_tick (period_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_byte(input logic en, input logic [1:0] m,
                                              input logic [1:0] frac);
        return {3'b000, frac, m, en};
    endfunction

    // Advance to a negedge where the tick is seen.
    task automatic sync_tick();
        for (int i = 0; i < 3000; i++) begin
            if (period_tick) return;
            @(negedge clk);
        end
        chk("R2 tick never seen", 0, 1);
    endtask

    // Count active cycles per line over len samples from the current negedge;
    // optional duty-register write issued after sample inj_at.
    task automatic measure(input int len, input int inj_at, input logic [7:0] inj_d);
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        tick_cnt = 0;
        compl_bad = 0;
        for (int i = 0; i < len; i++) begin
            for (int k = 0; k < 4; k++) cnt[k] += int'(pwm_lines[k]);
            tick_cnt += int'(period_tick);
            if (pwm_lines[1] == pwm_lines[0]) compl_bad++;
            if (i == inj_at) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = inj_d;
            end
            if (i == inj_at + 1) wr_en = 1'b0;
            @(negedge clk);
        end
        next_tick = period_tick;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 lines in reset", int'(pwm_lines), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 lines after reset", int'(pwm_lines), 0);
        chk("R1 tick after reset", int'(period_tick), 0);

        // Table of mode / period / duty vectors
        foreach (VECS[v]) begin
            int len, d, ea, eb, ec, ed;
            string tag;
            len = (int'(VECS[v].period) + 1) * 4;
            d = int'(VECS[v].active);
            wr(2'd0, 8'h00);
            wr(2'd1, VECS[v].period);
            wr(2'd2, VECS[v].duty[9:2]);
            wr(2'd0, ctrl_byte(1'b1, VECS[v].mode, VECS[v].duty[1:0]));
            sync_tick();
            measure(len, -10, 8'h00);
            ea = 0; eb = 0; ec = 0; ed = 0;
            case (VECS[v].mode)
                2'b00: begin tag = "R8/R3/R4/R5 single";  ea = d; end
                2'b01: begin tag = "R9/R3/R4/R5 half";    ea = d; eb = len - d; end
                2'b10: begin tag = "R10/R3/R4/R5 forward"; ea = len; ed = d; end
                default: begin tag = "R11/R3/R4/R5 reverse"; eb = d; ec = len; end
            endcase
            chk({tag, " line A"}, cnt[0], ea);
            chk({tag, " line B"}, cnt[1], eb);
            chk({tag, " line C"}, cnt[2], ec);
            chk({tag, " line D"}, cnt[3], ed);
            chk("R2 one tick per period", tick_cnt, 1);
            chk("R2 tick after period length", int'(next_tick), 1);
            if (VECS[v].mode == 2'b01)
                chk("R9 B complements A", compl_bad, 0);
        end

        // R6 duty double buffering: write mid-period, effect next period
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd7);
        wr(2'd2, 8'd2);
        wr(2'd0, ctrl_byte(1'b1, 2'b00, 2'b00));
        sync_tick();
        measure(32, 3, 8'd5);
        chk("R6 current period keeps old duty", cnt[0], 8);
        measure(32, -10, 8'h00);
        chk("R6 next period uses new duty", cnt[0], 20);

        // R7 clearing control silences all lines, including held-high ones
        wr(2'd0, ctrl_byte(1'b1, 2'b10, 2'b00));
        sync_tick();
        repeat (3) @(negedge clk);
        chk("R10 line A held high before clear", int'(pwm_lines[0]), 1);
        wr(2'd0, 8'h00);
        chk("R7 lines low after clear", int'(pwm_lines), 0);
        measure(40, -10, 8'h00);
        chk("R7 no activity while disabled", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
        chk("R7 no tick while disabled", tick_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule